// File: doc/BRIEF.md
# Register File and Flag Execute Unit

This block is the 16-bit execute stage of a small processor. It owns the working registers (X, Y, Z, a target register, a status register and a call-origin register). In one cycle it performs a logic or data-move operation on two operands and updates the status flags. Each operand is either a register, picked by a 4-bit code, or a memory-space operand. A memory-space operand arrives with its value and its address already resolved. Results bound for memory leave the block as a registered write request: a data word, an address and a one-cycle write enable.

Two relative-copy operations use the target register as a signed address offset, with the direction chosen by a sign input. The store form moves an operand value to a memory address displaced by the target register. The load form presents a displaced address on a combinational fetch port. It expects the word at that address back in the same cycle and then writes that word to the second operand.

Top module: `xu_core`

## Requirements
- R1: After reset, X, Y, Z, target and call-origin are 0, `status_o` is 0x40 (only the stack-empty flag, bit 6, is set), `res_o` is 0 and `mem_we_o` is 0. The status bits, counted from bit 0, are: zero, equal, less-than, greater-than, carry, infinity, stack-empty, stack-full.
- R2: Register codes are 1=X, 2=Y, 3=Z, 4=target, 5=status, 6=call-origin, and any other code is the null register. Writes to codes 1–4 land in the named register. Reading the target register or the null register as an operand gives 0.
- R3: Reading code 5 gives the 8 status bits, zero-extended. Writes to code 5, code 6 or the null register change no register. Only the flags that the operation itself defines change.
- R4: Compare (op 1) sets equal, less-than and greater-than from an unsigned comparison of A against B. It sets zero when either operand is 0. It writes no register and raises no memory write.
- R5: AND (op 2), OR (op 3) and XOR (op 4) write the result to operand A and set zero when the result is 0.
- R6: Complement (op 5) and increment (op 6) write to operand A and set zero from the result. Increment wraps 0xFFFF to 0x0000.
- R7: Copy (op 7) moves the value of A to operand B. Immediate copy (op 8) moves `a_val_i` to operand B. Both change only the zero flag, which reflects the moved value.
- R8: Relative store (op 9) writes the value of A to address `b_addr_i + target` when `sign_i` is 1 and to `b_addr_i - target` when it is 0, modulo 2^16. It sets zero from the value.
- R9: Relative load (op 10) drives `fetch_addr_o` with `a_addr_i ± target`, using the same sign rule. It writes `fetch_data_i` to operand B and sets zero from that value. If A is a register, its register value is moved instead.
- R10: Results are registered. A memory destination raises `mem_we_o` for exactly the one cycle after the operation is issued. With `valid_i` low, or with op 0 or any unused opcode, no register, flag or output changes, and `mem_we_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Issue an operation this cycle |
| op_i | input | 4 | Operation code |
| sign_i | input | 1 | Offset direction for relative copies (1 = add) |
| a_mem_i | input | 1 | Operand A is memory-space |
| a_code_i | input | 4 | Register code of operand A |
| a_val_i | input | 16 | Memory value of A, or immediate |
| a_addr_i | input | 16 | Memory address of A |
| b_mem_i | input | 1 | Operand B is memory-space |
| b_code_i | input | 4 | Register code of operand B |
| b_val_i | input | 16 | Memory value of B |
| b_addr_i | input | 16 | Memory address of B |
| fetch_addr_o | output | 16 | Displaced load address (combinational) |
| fetch_data_i | input | 16 | Word read at `fetch_addr_o` |
| res_o | output | 16 | Registered result |
| mem_we_o | output | 1 | Registered memory write enable |
| mem_addr_o | output | 16 | Registered memory write address |
| status_o | output | 8 | Status flags |
| x_o | output | 16 | X register |
| y_o | output | 16 | Y register |
| z_o | output | 16 | Z register |
| tgt_o | output | 16 | Target register |

## Verification
The assertions assume that the operand fields are stable and meaningful whenever `valid_i` is high. They also assume that `fetch_data_i` settles from `fetch_addr_o` within the same cycle. The bench drives every input on the falling edge and returns fetch data from a fixed function of the fetch address, so that data settles well before the next rising edge. The bench issues each operation for a single cycle and holds `valid_i` low between bursts. This lets the write-enable pulse and the idle-cycle properties be observed in isolation.

// File: rtl/xu_pkg.sv
package xu_pkg;
  localparam int unsigned FLAG_W = 8;

  localparam int unsigned F_ZERO  = 0;
  localparam int unsigned F_EQ    = 1;
  localparam int unsigned F_LT    = 2;
  localparam int unsigned F_GT    = 3;
  localparam int unsigned F_EMPTY = 6;

  localparam logic [FLAG_W-1:0] STATUS_RST = 8'h40;

  typedef enum logic [3:0] {
    OP_NOP  = 4'd0,
    OP_CMP  = 4'd1,
    OP_AND  = 4'd2,
    OP_OR   = 4'd3,
    OP_XOR  = 4'd4,
    OP_CMPL = 4'd5,
    OP_INC  = 4'd6,
    OP_CPY  = 4'd7,
    OP_ICPY = 4'd8,
    OP_RCPT = 4'd9,
    OP_RCPF = 4'd10
  } op_e;

  typedef enum logic [3:0] {
    RC_NULL = 4'd0,
    RC_X    = 4'd1,
    RC_Y    = 4'd2,
    RC_Z    = 4'd3,
    RC_TGT  = 4'd4,
    RC_STAT = 4'd5,
    RC_CALL = 4'd6
  } rcode_e;

  typedef enum logic [1:0] {
    DST_NONE = 2'd0,
    DST_A    = 2'd1,
    DST_B    = 2'd2
  } dst_e;
endpackage

// File: rtl/xu_offset.sv
module xu_offset #(
  parameter int unsigned W = 16
) (
  input  logic [W-1:0] base_i,
  input  logic [W-1:0] off_i,
  input  logic         add_i,
  output logic [W-1:0] addr_o
);
  // wraps modulo 2^W by width truncation
  always_comb begin
    if (add_i) addr_o = base_i + off_i;
    else       addr_o = base_i - off_i;
  end
endmodule

// File: rtl/xu_regfile.sv
module xu_regfile
  import xu_pkg::*;
#(
  parameter int unsigned W   = 16,
  parameter int unsigned NRD = 2
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic [NRD-1:0][3:0]      rd_code_i,
  output logic [NRD-1:0][W-1:0]    rd_val_o,
  input  logic                     wr_en_i,
  input  logic [3:0]               wr_code_i,
  input  logic [W-1:0]             wr_data_i,
  input  logic [FLAG_W-1:0]        flag_mask_i,
  input  logic [FLAG_W-1:0]        flag_val_i,
  output logic [FLAG_W-1:0]        status_o,
  output logic [W-1:0]             x_o,
  output logic [W-1:0]             y_o,
  output logic [W-1:0]             z_o,
  output logic [W-1:0]             tgt_o
);
  localparam int unsigned PAD = W - FLAG_W;

  logic [W-1:0]      x_q, y_q, z_q, tgt_q, call_q;
  logic [FLAG_W-1:0] status_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      x_q    <= '0;
      y_q    <= '0;
      z_q    <= '0;
      tgt_q  <= '0;
      call_q <= '0;
    end else if (wr_en_i) begin
      unique case (wr_code_i)
        RC_X:    x_q   <= wr_data_i;
        RC_Y:    y_q   <= wr_data_i;
        RC_Z:    z_q   <= wr_data_i;
        RC_TGT:  tgt_q <= wr_data_i;
        default: ;  // status, call-origin, null: dropped
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) status_q <= STATUS_RST;
    else         status_q <= (status_q & ~flag_mask_i) | (flag_val_i & flag_mask_i);
  end

  for (genvar p = 0; p < NRD; p++) begin : g_rd
    always_comb begin
      unique case (rd_code_i[p])
        RC_X:    rd_val_o[p] = x_q;
        RC_Y:    rd_val_o[p] = y_q;
        RC_Z:    rd_val_o[p] = z_q;
        RC_STAT: rd_val_o[p] = {{PAD{1'b0}}, status_q};
        RC_CALL: rd_val_o[p] = call_q;
        default: rd_val_o[p] = '0;  // target and null read as zero
      endcase
    end
  end

  assign status_o = status_q;
  assign x_o      = x_q;
  assign y_o      = y_q;
  assign z_o      = z_q;
  assign tgt_o    = tgt_q;

  assert_cmp_flags_exclusive_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(status_q[F_GT:F_EQ]));

  assert_x_write_lands_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_code_i == RC_X) |=> (x_q == $past(wr_data_i)));

  assert_stat_write_dropped_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_code_i == RC_STAT) |=> ($stable(x_q) && $stable(y_q) && $stable(z_q) && $stable(tgt_q)));
endmodule

// File: rtl/xu_logic.sv
module xu_logic
  import xu_pkg::*;
#(
  parameter int unsigned W = 16
) (
  input  logic [3:0]        op_i,
  input  logic [W-1:0]      a_i,
  input  logic [W-1:0]      b_i,
  input  logic [W-1:0]      imm_i,
  input  logic [W-1:0]      load_i,
  output logic [W-1:0]      res_o,
  output dst_e              dst_o,
  output logic [FLAG_W-1:0] fmask_o,
  output logic [FLAG_W-1:0] fval_o
);
  logic [W-1:0] r;
  logic         set_z;

  always_comb begin
    r       = '0;
    dst_o   = DST_NONE;
    set_z   = 1'b0;
    fmask_o = '0;
    fval_o  = '0;
    unique case (op_i)
      OP_CMP: begin
        fmask_o[F_ZERO] = 1'b1;
        fmask_o[F_EQ]   = 1'b1;
        fmask_o[F_LT]   = 1'b1;
        fmask_o[F_GT]   = 1'b1;
        fval_o[F_ZERO]  = (a_i == '0) || (b_i == '0);
        fval_o[F_EQ]    = (a_i == b_i);
        fval_o[F_LT]    = (a_i <  b_i);
        fval_o[F_GT]    = (a_i >  b_i);
      end
      OP_AND:  begin r = a_i & b_i;     dst_o = DST_A; set_z = 1'b1; end
      OP_OR:   begin r = a_i | b_i;     dst_o = DST_A; set_z = 1'b1; end
      OP_XOR:  begin r = a_i ^ b_i;     dst_o = DST_A; set_z = 1'b1; end
      OP_CMPL: begin r = ~a_i;          dst_o = DST_A; set_z = 1'b1; end
      OP_INC:  begin r = a_i + 1'b1;    dst_o = DST_A; set_z = 1'b1; end
      OP_CPY:  begin r = a_i;           dst_o = DST_B; set_z = 1'b1; end
      OP_ICPY: begin r = imm_i;         dst_o = DST_B; set_z = 1'b1; end
      OP_RCPT: begin r = a_i;           dst_o = DST_B; set_z = 1'b1; end
      OP_RCPF: begin r = load_i;        dst_o = DST_B; set_z = 1'b1; end
      default: ;
    endcase
    if (set_z) begin
      fmask_o[F_ZERO] = 1'b1;
      fval_o[F_ZERO]  = (r == '0);
    end
    res_o = r;
  end
endmodule

// File: rtl/xu_core.sv
module xu_core
  import xu_pkg::*;
#(
  parameter int unsigned W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [3:0]        op_i,
  input  logic              sign_i,
  input  logic              a_mem_i,
  input  logic [3:0]        a_code_i,
  input  logic [W-1:0]      a_val_i,
  input  logic [W-1:0]      a_addr_i,
  input  logic              b_mem_i,
  input  logic [3:0]        b_code_i,
  input  logic [W-1:0]      b_val_i,
  input  logic [W-1:0]      b_addr_i,
  output logic [W-1:0]      fetch_addr_o,
  input  logic [W-1:0]      fetch_data_i,
  output logic [W-1:0]      res_o,
  output logic              mem_we_o,
  output logic [W-1:0]      mem_addr_o,
  output logic [FLAG_W-1:0] status_o,
  output logic [W-1:0]      x_o,
  output logic [W-1:0]      y_o,
  output logic [W-1:0]      z_o,
  output logic [W-1:0]      tgt_o
);
  localparam int unsigned NOPND = 2;

  logic [NOPND-1:0][3:0]   rd_code;
  logic [NOPND-1:0][W-1:0] rd_val;
  logic [NOPND-1:0][W-1:0] base_addr;
  logic [NOPND-1:0][W-1:0] off_addr;

  logic [W-1:0]      opnd_a, opnd_b, load_val, alu_res;
  dst_e              dst;
  logic [FLAG_W-1:0] fmask, fval;
  logic              dst_mem;
  logic [3:0]        dst_code;
  logic [W-1:0]      dst_addr;
  logic              rf_we;

  logic [W-1:0] res_q, mem_addr_q;
  logic         mem_we_q;

  assign rd_code[0]   = a_code_i;
  assign rd_code[1]   = b_code_i;
  assign base_addr[0] = a_addr_i;
  assign base_addr[1] = b_addr_i;

  for (genvar k = 0; k < NOPND; k++) begin : g_off
    xu_offset #(.W(W)) u_off (
      .base_i (base_addr[k]),
      .off_i  (tgt_o),
      .add_i  (sign_i),
      .addr_o (off_addr[k])
    );
  end

  assign fetch_addr_o = off_addr[0];
  assign opnd_a   = a_mem_i ? a_val_i : rd_val[0];
  assign opnd_b   = b_mem_i ? b_val_i : rd_val[1];
  assign load_val = a_mem_i ? fetch_data_i : rd_val[0];

  xu_logic #(.W(W)) u_logic (
    .op_i    (op_i),
    .a_i     (opnd_a),
    .b_i     (opnd_b),
    .imm_i   (a_val_i),
    .load_i  (load_val),
    .res_o   (alu_res),
    .dst_o   (dst),
    .fmask_o (fmask),
    .fval_o  (fval)
  );

  always_comb begin
    dst_mem  = 1'b0;
    dst_code = RC_NULL;
    dst_addr = '0;
    unique case (dst)
      DST_A: begin
        dst_mem  = a_mem_i;
        dst_code = a_code_i;
        dst_addr = a_addr_i;
      end
      DST_B: begin
        dst_mem  = b_mem_i;
        dst_code = b_code_i;
        dst_addr = (op_i == OP_RCPT) ? off_addr[1] : b_addr_i;
      end
      default: ;
    endcase
  end

  assign rf_we = valid_i && (dst != DST_NONE) && !dst_mem;

  xu_regfile #(.W(W), .NRD(NOPND)) u_rf (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .rd_code_i   (rd_code),
    .rd_val_o    (rd_val),
    .wr_en_i     (rf_we),
    .wr_code_i   (dst_code),
    .wr_data_i   (alu_res),
    .flag_mask_i (valid_i ? fmask : '0),
    .flag_val_i  (fval),
    .status_o    (status_o),
    .x_o         (x_o),
    .y_o         (y_o),
    .z_o         (z_o),
    .tgt_o       (tgt_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      res_q      <= '0;
      mem_we_q   <= 1'b0;
      mem_addr_q <= '0;
    end else begin
      mem_we_q <= valid_i && (dst != DST_NONE) && dst_mem;
      if (valid_i && (dst != DST_NONE)) begin
        res_q      <= alu_res;
        mem_addr_q <= dst_addr;
      end
    end
  end

  assign res_o      = res_q;
  assign mem_we_o   = mem_we_q;
  assign mem_addr_o = mem_addr_q;

  assert_cmp_no_write_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && op_i == OP_CMP) |=> ($stable(x_o) && $stable(y_o) && $stable(z_o) && $stable(tgt_o) && !mem_we_o));

  assert_we_needs_issue_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(valid_i) |-> !mem_we_o);

  assert_idle_holds_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> ($stable(status_o) && $stable(x_o) && $stable(res_o)));

  assert_inc_wraps_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && op_i == OP_INC && !a_mem_i && a_code_i == RC_X && x_o == '1) |=> (x_o == '0 && status_o[F_ZERO]));
endmodule

// File: tb/xu_core_bench.sv
module xu_core_bench;
  localparam int unsigned PERIOD = 10;
  localparam logic [15:0] FMIX = 16'hA5C3;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        valid = 1'b0;
  logic [3:0]  op = '0;
  logic        sign = 1'b0;
  logic        a_mem = 1'b0, b_mem = 1'b0;
  logic [3:0]  a_code = '0, b_code = '0;
  logic [15:0] a_val = '0, a_addr = '0, b_val = '0, b_addr = '0;
  logic [15:0] fetch_addr, fetch_data, res, mem_addr, x, y, z, tgt;
  logic        mem_we;
  logic [7:0]  status;

  int total = 0;
  int bad = 0;
  bit done = 0;

  // reference state
  logic [15:0] mx, my, mz, mt, mres, maddr;
  logic [7:0]  ms;
  logic        mwe;

  always #(PERIOD/2) clk = ~clk;
  assign fetch_data = fetch_addr ^ FMIX;

  xu_core u_xu_core (
    .clk_i(clk), .rst_ni(rst_ni), .valid_i(valid), .op_i(op), .sign_i(sign),
    .a_mem_i(a_mem), .a_code_i(a_code), .a_val_i(a_val), .a_addr_i(a_addr),
    .b_mem_i(b_mem), .b_code_i(b_code), .b_val_i(b_val), .b_addr_i(b_addr),
    .fetch_addr_o(fetch_addr), .fetch_data_i(fetch_data),
    .res_o(res), .mem_we_o(mem_we), .mem_addr_o(mem_addr), .status_o(status),
    .x_o(x), .y_o(y), .z_o(z), .tgt_o(tgt)
  );

  task automatic chk(input string tag, input string what, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic chk_all(input string tag);
    chk(tag, "x", x, mx);
    chk(tag, "y", y, my);
    chk(tag, "z", z, mz);
    chk(tag, "tgt", tgt, mt);
    chk(tag, "status", {8'h0, status}, {8'h0, ms});
    chk(tag, "res", res, mres);
    chk(tag, "we", {15'h0, mem_we}, {15'h0, mwe});
    if (mwe) chk(tag, "addr", mem_addr, maddr);
  endtask

  function automatic logic [15:0] rreg(input logic [3:0] c);
    case (c)
      4'd1: return mx;
      4'd2: return my;
      4'd3: return mz;
      4'd5: return {8'h0, ms};
      default: return 16'h0;  // target, call-origin (always 0), null
    endcase
  endfunction

  task automatic wreg(input logic [3:0] c, input logic [15:0] v);
    case (c)
      4'd1: mx = v;
      4'd2: my = v;
      4'd3: mz = v;
      4'd4: mt = v;
      default: ;
    endcase
  endtask

  // issue one operation at the falling edge, check after the next rising edge
  task automatic issue(input string tag, input logic [3:0] o,
                       input logic am, input logic [3:0] ac, input logic [15:0] av, input logic [15:0] aa,
                       input logic bm, input logic [3:0] bc, input logic [15:0] bv, input logic [15:0] ba,
                       input logic sg);
    logic [15:0] va, vb, r, fa, da;
    int dst;  // 0 none, 1 A, 2 B
    valid = 1'b1; op = o; sign = sg;
    a_mem = am; a_code = ac; a_val = av; a_addr = aa;
    b_mem = bm; b_code = bc; b_val = bv; b_addr = ba;
    va = am ? av : rreg(ac);
    vb = bm ? bv : rreg(bc);
    fa = sg ? aa + mt : aa - mt;
    dst = 0; r = 16'h0;
    case (o)
      4'd1: begin
        ms[0] = (va == 0) || (vb == 0);
        ms[1] = (va == vb);
        ms[2] = (va < vb);
        ms[3] = (va > vb);
      end
      4'd2: begin r = va & vb; dst = 1; end
      4'd3: begin r = va | vb; dst = 1; end
      4'd4: begin r = va ^ vb; dst = 1; end
      4'd5: begin r = ~va;     dst = 1; end
      4'd6: begin r = va + 16'd1; dst = 1; end
      4'd7: begin r = va; dst = 2; end
      4'd8: begin r = av; dst = 2; end
      4'd9: begin r = va; dst = 2; end
      4'd10: begin r = am ? (fa ^ FMIX) : va; dst = 2; end
      default: ;
    endcase
    #1;
    if (o == 4'd10) chk(tag, "fetch_addr", fetch_addr, fa);
    @(posedge clk);
    @(negedge clk);
    valid = 1'b0;
    mwe = 1'b0;
    if (dst != 0) begin
      ms[0] = (r == 0);
      mres = r;
      if ((dst == 1 && am) || (dst == 2 && bm)) begin
        da = (dst == 1) ? aa : ((o == 4'd9) ? (sg ? ba + mt : ba - mt) : ba);
        mwe = 1'b1;
        maddr = da;
      end else begin
        wreg((dst == 1) ? ac : bc, r);
      end
    end
    chk_all(tag);
  endtask

  task automatic idle(input string tag);
    valid = 1'b0;
    a_val = 16'hDEAD; op = 4'd2;
    @(posedge clk);
    @(negedge clk);
    mwe = 1'b0;
    chk_all(tag);
  endtask

  initial begin
    #(PERIOD * 50000);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    mx = 0; my = 0; mz = 0; mt = 0; ms = 8'h40; mres = 0; maddr = 0; mwe = 0;
    repeat (3) @(negedge clk);
    chk_all("R1");
    rst_ni = 1'b1;
    @(negedge clk);
    chk_all("R1");

    // immediate and register copies (R7, R2)
    issue("R7", 4'd8, 0, 0, 16'h1234, 0, 0, 4'd1, 0, 0, 0);
    issue("R7", 4'd8, 0, 0, 16'hFFFF, 0, 0, 4'd2, 0, 0, 0);
    issue("R7", 4'd8, 0, 0, 16'h0000, 0, 0, 4'd3, 0, 0, 0);
    issue("R2", 4'd8, 0, 0, 16'h0003, 0, 0, 4'd4, 0, 0, 0);
    issue("R7", 4'd7, 0, 4'd1, 0, 0, 1, 0, 0, 16'h0100, 0);
    issue("R2", 4'd7, 0, 4'd4, 0, 0, 0, 4'd3, 0, 0, 0);   // target reads 0
    issue("R2", 4'd7, 0, 4'd9, 0, 0, 0, 4'd3, 0, 0, 0);   // null reads 0
    issue("R2", 4'd6, 0, 4'd4, 0, 0, 0, 0, 0, 0, 0);      // inc target: 0+1
    issue("R2", 4'd8, 0, 0, 16'h0003, 0, 0, 4'd4, 0, 0, 0);

    // ignored writes and status read (R3)
    issue("R3", 4'd8, 0, 0, 16'h00FF, 0, 0, 4'd5, 0, 0, 0);
    issue("R3", 4'd8, 0, 0, 16'h7777, 0, 0, 4'd6, 0, 0, 0);
    issue("R3", 4'd8, 0, 0, 16'h5555, 0, 0, 4'd15, 0, 0, 0);
    issue("R3", 4'd7, 0, 4'd6, 0, 0, 0, 4'd3, 0, 0, 0);   // call-origin reads 0
    issue("R3", 4'd7, 0, 4'd5, 0, 0, 0, 4'd3, 0, 0, 0);

    // compare (R4)
    issue("R4", 4'd1, 0, 4'd1, 0, 0, 0, 4'd2, 0, 0, 0);
    issue("R4", 4'd1, 0, 4'd2, 0, 0, 0, 4'd1, 0, 0, 0);
    issue("R4", 4'd1, 1, 0, 16'h1234, 0, 0, 4'd1, 0, 0, 0);
    issue("R4", 4'd1, 0, 4'd1, 0, 0, 0, 4'd4, 0, 0, 0);
    issue("R4", 4'd1, 1, 0, 16'h0000, 0, 1, 0, 16'h0000, 0, 0);
    issue("R4", 4'd1, 1, 0, 16'h8000, 0, 1, 0, 16'h7FFF, 0, 0);

    // logic ops (R5)
    issue("R5", 4'd2, 0, 4'd1, 0, 0, 0, 4'd2, 0, 0, 0);
    issue("R5", 4'd3, 0, 4'd3, 0, 0, 1, 0, 16'h0F0F, 0, 0);
    issue("R5", 4'd4, 0, 4'd1, 0, 0, 0, 4'd1, 0, 0, 0);
    issue("R5", 4'd2, 1, 0, 16'h00F0, 16'h0200, 1, 0, 16'h0F00, 0, 0);
    issue("R5", 4'd4, 1, 0, 16'hAAAA, 16'h0300, 0, 4'd3, 0, 0, 0);

    // complement and increment (R6)
    issue("R6", 4'd5, 0, 4'd3, 0, 0, 0, 0, 0, 0, 0);
    issue("R6", 4'd6, 0, 4'd2, 0, 0, 0, 0, 0, 0, 0);
    issue("R6", 4'd8, 0, 0, 16'hFFFF, 0, 0, 4'd1, 0, 0, 0);
    issue("R6", 4'd6, 0, 4'd1, 0, 0, 0, 0, 0, 0, 0);
    issue("R6", 4'd5, 1, 0, 16'hFFFF, 16'h0400, 0, 0, 0, 0, 0);

    // relative store (R8)
    issue("R8", 4'd8, 0, 0, 16'h0042, 0, 0, 4'd3, 0, 0, 0);
    issue("R8", 4'd9, 0, 4'd3, 0, 0, 1, 0, 0, 16'h1000, 1);
    issue("R8", 4'd9, 0, 4'd3, 0, 0, 1, 0, 0, 16'h1000, 0);
    issue("R8", 4'd9, 0, 4'd3, 0, 0, 1, 0, 0, 16'h0001, 0);
    issue("R8", 4'd9, 0, 4'd1, 0, 0, 1, 0, 0, 16'hFFFE, 1);

    // relative load (R9)
    issue("R9", 4'd10, 1, 0, 0, 16'h2000, 0, 4'd1, 0, 0, 1);
    issue("R9", 4'd10, 1, 0, 0, 16'h0002, 0, 4'd2, 0, 0, 0);
    issue("R9", 4'd10, 1, 0, 0, 16'h2000, 1, 0, 0, 16'h0500, 0);
    issue("R9", 4'd10, 1, 0, 0, FMIX - 16'd3, 0, 4'd3, 0, 0, 1);
    issue("R9", 4'd10, 0, 4'd1, 0, 16'h2000, 0, 4'd3, 0, 0, 1);

    // idle cycles and unused opcodes (R10)
    idle("R10");
    idle("R10");
    issue("R10", 4'd0, 0, 4'd1, 16'h1111, 0, 1, 0, 0, 16'h0600, 0);
    issue("R10", 4'd13, 0, 4'd1, 16'h1111, 0, 1, 0, 0, 16'h0600, 0);
    issue("R10", 4'd7, 0, 4'd1, 0, 0, 1, 0, 0, 16'h0700, 0);
    idle("R10");

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule